// File: doc/BRIEF.md
# Phase-Addressed Drive Status Latch

This block answers status queries from a vintage disk host controller one bit at a time. The host places a code on four phase/select lines, and the block returns the status bit that the code names on a single read-data line. The block keeps two banks of status in one 24-entry table. One bank is a 16-bit floppy status word. The other is an 8-bit hard-disk status word. A disk-mode flag chooses which bank the phase lines address.

A local controller changes the status through a small write port. Each write either sets or clears one table entry, chosen by a 5-bit index. Two dedicated pulse inputs lower or raise the hard-disk handshake pair as a unit. The read-data line is driven only while the host's active-low enable is low. At other times the output-enable is low and the line is released.

The phase lines are asynchronous to the block's clock, so they pass through a two-flop synchroniser before they are decoded. The result is held in a registered output bit. Every table update takes part in the same cycle's lookup, so a change to the addressed bit shows on the very next clock edge.

Top module: `drive_status_latch`

## Requirements
- R1: Reset is synchronous and active high. After reset every floppy status entry (table 0..15) reads 1, and `rd_oe_o` is 0.
- R2: After reset, hard-disk status bits 0..5 (table 16..21) read 0 and bits 6..7 (table 22..23) read 1.
- R3: With `hd_mode_i`=0, the table entry read is `phase_i` as an unsigned number, with `phase_i[0]` as the LSB, giving entries 0..15.
- R4: With `hd_mode_i`=1, the entry read is 16 + `phase_i[2:0]`, and `phase_i[3]` has no effect.
- R5: A change on `phase_i` reaches `rd_data_o` on the third rising edge after it is applied (two synchroniser stages, then the output register). A change on `hd_mode_i` reaches it on the first rising edge.
- R6: `rd_oe_o` equals the inverse of `enable_n_i` delayed by two rising edges. Whenever `rd_oe_o` is 0, `rd_data_o` is 0.
- R7: A cycle with `wr_en_i`=1 and `wr_idx_i` in 0..23 loads `wr_val_i` into that table entry, leaving all other entries unchanged. Indices 24..31 change nothing.
- R8: A write to the entry that is currently addressed shows on `rd_data_o` at the first rising edge after it is applied.
- R9: A pulse on `hs_assert_i` clears hard-disk bits 2 and 3 (table 18 and 19), and a pulse on `hs_release_i` sets them. If both pulses arrive in the same cycle, the clear wins. On those two entries a handshake pulse overrides the write port. The result is visible at the next rising edge when the pair is addressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 4 | Asynchronous phase/select lines from the host |
| hd_mode_i | input | 1 | Bank select: 0 floppy, 1 hard disk |
| enable_n_i | input | 1 | Asynchronous active-low drive enable |
| wr_en_i | input | 1 | Write strobe for the status table |
| wr_idx_i | input | 5 | Table entry to write |
| wr_val_i | input | 1 | Value to write (1 set, 0 clear) |
| hs_assert_i | input | 1 | Pulse: clear the handshake pair |
| hs_release_i | input | 1 | Pulse: set the handshake pair |
| rd_data_o | output | 1 | Addressed status bit, forced to 0 while not driven |
| rd_oe_o | output | 1 | Output enable for the read-data pad |

## Verification
Each result has its own delay after its stimulus. A phase change takes three rising edges to reach `rd_data_o`, an enable change takes two edges to reach `rd_oe_o`, and a mode switch, a write or a handshake pulse takes one edge. The bench drives inputs on the falling edge and samples on the next falling edge. It runs a reference pipeline with these same delays, and the directed latency checks sample at each intermediate edge to show that the old value persists until the due edge. Writes to indices 24..31 are checked by sweeping all 24 addresses afterwards and comparing every entry.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    localparam int FLOPPY_BITS = 16;
    localparam int HD_BITS     = 8;
    localparam int TABLE_DEPTH = FLOPPY_BITS + HD_BITS;
    localparam int IDX_W       = $clog2(TABLE_DEPTH);
    localparam int PHASE_W     = $clog2(FLOPPY_BITS);
    localparam int HD_SEL_W    = $clog2(HD_BITS);
    localparam int HD_BASE     = FLOPPY_BITS;
    localparam int PAD_DEPTH   = 1 << IDX_W;

    // hard-disk bank positions of the handshake pair
    localparam int HS_LO_BIT   = 2;
    localparam int HS_HI_BIT   = 3;
    localparam int HS_LO_IDX   = HD_BASE + HS_LO_BIT;
    localparam int HS_HI_IDX   = HD_BASE + HS_HI_BIT;

    localparam logic [HD_BITS-1:0] HD_PRESET = 8'b1100_0000;

    typedef logic [TABLE_DEPTH-1:0] status_tbl_t;
    typedef logic [IDX_W-1:0]       tbl_idx_t;

    typedef struct packed {
        logic               hd_mode;
        logic [PHASE_W-1:0] phase;
    } look_addr_t;

    typedef struct packed {
        logic     en;
        tbl_idx_t idx;
        logic     val;
    } bit_wr_t;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_LOWER   = 2'd1,
        HS_RAISE   = 2'd2
    } hs_cmd_t;

    function automatic status_tbl_t preset_table();
        status_tbl_t t;
        t = '0;
        t[FLOPPY_BITS-1:0] = '1;
        t[HD_BASE +: HD_BITS] = HD_PRESET;
        return t;
    endfunction

    function automatic tbl_idx_t table_index(look_addr_t a);
        tbl_idx_t r;
        if (a.hd_mode)
            r = tbl_idx_t'(HD_BASE) + tbl_idx_t'(a.phase[HD_SEL_W-1:0]);
        else
            r = tbl_idx_t'(a.phase);
        return r;
    endfunction

    function automatic hs_cmd_t hs_decode(logic lower, logic raise);
        hs_cmd_t c;
        if (lower)      c = HS_LOWER;
        else if (raise) c = HS_RAISE;
        else            c = HS_IDLE;
        return c;
    endfunction

endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= {WIDTH{RST_VAL}};
                else     stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= {WIDTH{RST_VAL}};
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dsl_status_table.sv
module dsl_status_table
    import dsl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bit_wr_t     wr_i,
    input  hs_cmd_t     hs_i,
    output status_tbl_t tbl_q_o,
    output status_tbl_t tbl_nxt_o
);

    status_tbl_t tbl_q;

    for (genvar i = 0; i < TABLE_DEPTH; i++) begin : g_entry
        localparam bit IS_HS = (i == HS_LO_IDX) || (i == HS_HI_IDX);
        logic wr_hit;
        logic nxt;

        assign wr_hit = wr_i.en && (wr_i.idx == tbl_idx_t'(i));

        always_comb begin
            nxt = tbl_q[i];
            if (wr_hit)
                nxt = wr_i.val;
            if (IS_HS) begin
                if (hs_i == HS_LOWER)      nxt = 1'b0;
                else if (hs_i == HS_RAISE) nxt = 1'b1;
            end
        end

        assign tbl_nxt_o[i] = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= preset_table();
        else     tbl_q <= tbl_nxt_o;
    end

    assign tbl_q_o = tbl_q;

endmodule

// File: rtl/dsl_bit_select.sv
module dsl_bit_select
    import dsl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  status_tbl_t tbl_nxt_i,
    input  look_addr_t  addr_i,
    output tbl_idx_t    look_idx_o,
    output logic        bit_q_o
);

    logic [PAD_DEPTH-1:0] padded;
    logic                 bit_q;

    assign look_idx_o = table_index(addr_i);
    assign padded     = {{(PAD_DEPTH-TABLE_DEPTH){1'b0}}, tbl_nxt_i};

    always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= padded[look_idx_o];
    end

    assign bit_q_o = bit_q;

endmodule

// File: rtl/drive_status_latch.sv
module drive_status_latch
    import dsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               hd_mode_i,
    input  logic               enable_n_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic               wr_val_i,
    input  logic               hs_assert_i,
    input  logic               hs_release_i,
    output logic               rd_data_o,
    output logic               rd_oe_o
);

    logic [PHASE_W-1:0] phase_s;
    logic               enable_n_s;
    look_addr_t         look_addr;
    tbl_idx_t           look_idx;
    bit_wr_t            wr;
    hs_cmd_t            hs_cmd;
    status_tbl_t        tbl_q;
    status_tbl_t        tbl_nxt;
    logic               rd_bit_q;

    dsl_sync #(.WIDTH(PHASE_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_phase_sync (
        .clk (clk),
        .rst (rst),
        .d_i (phase_i),
        .q_o (phase_s)
    );

    dsl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_enable_sync (
        .clk (clk),
        .rst (rst),
        .d_i (enable_n_i),
        .q_o (enable_n_s)
    );

    assign wr.en      = wr_en_i;
    assign wr.idx     = wr_idx_i;
    assign wr.val     = wr_val_i;
    assign hs_cmd     = hs_decode(hs_assert_i, hs_release_i);

    dsl_status_table u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .hs_i      (hs_cmd),
        .tbl_q_o   (tbl_q),
        .tbl_nxt_o (tbl_nxt)
    );

    assign look_addr.hd_mode = hd_mode_i;
    assign look_addr.phase   = phase_s;

    dsl_bit_select u_select (
        .clk        (clk),
        .rst        (rst),
        .tbl_nxt_i  (tbl_nxt),
        .addr_i     (look_addr),
        .look_idx_o (look_idx),
        .bit_q_o    (rd_bit_q)
    );

    assign rd_oe_o   = ~enable_n_s;
    assign rd_data_o = rd_oe_o & rd_bit_q;

    logic unused_tbl;
    assign unused_tbl = ^tbl_q;

endmodule

// File: rtl/dsl_checker.sv
module dsl_checker
    import dsl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               hd_mode_i,
    input logic               enable_n_i,
    input logic               wr_en_i,
    input logic [IDX_W-1:0]   wr_idx_i,
    input logic               wr_val_i,
    input logic               hs_assert_i,
    input logic               hs_release_i,
    input logic               rd_data_o,
    input logic               rd_oe_o,
    input tbl_idx_t           look_idx,
    input logic               rd_bit
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_oe_o);

    // R6
    gated_out_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_oe_o |-> !rd_data_o);

    // R6
    enable_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (rd_oe_o == !$past(enable_n_i, 2)));

    // R3
    floppy_bank_chk: assert property (@(posedge clk) disable iff (rst)
        !hd_mode_i |-> (look_idx < tbl_idx_t'(HD_BASE)));

    // R4
    hd_bank_chk: assert property (@(posedge clk) disable iff (rst)
        hd_mode_i |-> (look_idx >= tbl_idx_t'(HD_BASE) && look_idx < tbl_idx_t'(TABLE_DEPTH)));

    // R8
    write_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i == look_idx && !hs_assert_i && !hs_release_i)
        |=> (rd_bit == $past(wr_val_i)));

    // R9
    hs_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_assert_i && (look_idx == tbl_idx_t'(HS_LO_IDX) || look_idx == tbl_idx_t'(HS_HI_IDX)))
        |=> !rd_bit);

    // R9
    hs_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_release_i && !hs_assert_i &&
         (look_idx == tbl_idx_t'(HS_LO_IDX) || look_idx == tbl_idx_t'(HS_HI_IDX)))
        |=> rd_bit);

endmodule

bind drive_status_latch dsl_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .hd_mode_i    (hd_mode_i),
    .enable_n_i   (enable_n_i),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_val_i     (wr_val_i),
    .hs_assert_i  (hs_assert_i),
    .hs_release_i (hs_release_i),
    .rd_data_o    (rd_data_o),
    .rd_oe_o      (rd_oe_o),
    .look_idx     (look_idx),
    .rd_bit       (rd_bit_q)
);

// File: tb/drive_status_latch_tb.sv
module drive_status_latch_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] phase_i;
    logic       hd_mode_i;
    logic       enable_n_i;
    logic       wr_en_i;
    logic [4:0] wr_idx_i;
    logic       wr_val_i;
    logic       hs_assert_i;
    logic       hs_release_i;
    logic       rd_data_o;
    logic       rd_oe_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    drive_status_latch u_dut (
        .clk          (clk),
        .rst          (rst),
        .phase_i      (phase_i),
        .hd_mode_i    (hd_mode_i),
        .enable_n_i   (enable_n_i),
        .wr_en_i      (wr_en_i),
        .wr_idx_i     (wr_idx_i),
        .wr_val_i     (wr_val_i),
        .hs_assert_i  (hs_assert_i),
        .hs_release_i (hs_release_i),
        .rd_data_o    (rd_data_o),
        .rd_oe_o      (rd_oe_o)
    );

    // reference pipeline built from the requirements
    logic [23:0] m_tbl;
    logic [3:0]  m_p1, m_p2;
    logic        m_e1, m_e2;
    logic        m_bit;

    function automatic logic [23:0] preset_ref();
        return {8'b1100_0000, 16'hFFFF};                 // R1 R2
    endfunction

    function automatic int idx_ref(logic mode, logic [3:0] ph);
        return mode ? 16 + int'(ph[2:0]) : int'(ph);     // R3 R4
    endfunction

    function automatic logic [23:0] next_ref(logic [23:0] t);
        logic [23:0] n = t;
        if (wr_en_i && wr_idx_i < 5'd24) n[wr_idx_i] = wr_val_i;   // R7
        if (hs_assert_i)       begin n[18] = 1'b0; n[19] = 1'b0; end // R9
        else if (hs_release_i) begin n[18] = 1'b1; n[19] = 1'b1; end
        return n;
    endfunction

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(string req);
        logic [23:0] n;
        @(posedge clk);
        n = next_ref(m_tbl);
        if (rst) begin
            m_tbl = preset_ref();
            m_p1 = '0; m_p2 = '0; m_e1 = 1'b1; m_e2 = 1'b1; m_bit = 1'b0;
        end else begin
            m_bit = n[idx_ref(hd_mode_i, m_p2)];
            m_tbl = n;
            m_p2  = m_p1; m_p1 = phase_i;
            m_e2  = m_e1; m_e1 = enable_n_i;
        end
        @(negedge clk);
        chk(req, rd_oe_o, !m_e2, "rd_oe_o");
        chk(req, rd_data_o, !m_e2 & m_bit, "rd_data_o");
    endtask

    task automatic idle_inputs();
        wr_en_i = 1'b0; wr_idx_i = '0; wr_val_i = 1'b0;
        hs_assert_i = 1'b0; hs_release_i = 1'b0;
    endtask

    task automatic read_at(logic mode, logic [3:0] ph, logic exp, string req);
        hd_mode_i = mode; phase_i = ph;
        step(req); step(req); step(req);
        chk(req, rd_data_o, exp, "addressed bit");
    endtask

    task automatic write_bit(int idx, logic val);
        wr_en_i = 1'b1; wr_idx_i = 5'(idx); wr_val_i = val;
        step("R7");
        idle_inputs();
    endtask

    task automatic sweep_all(string req);
        for (int i = 0; i < 24; i++) begin
            if (i < 16) read_at(1'b0, 4'(i), m_tbl[i], req);
            else        read_at(1'b1, 4'(i - 16), m_tbl[i], req);
        end
    endtask

    initial begin
        void'($urandom(32'h00C0_FFEE));
        rst = 1'b1; phase_i = '0; hd_mode_i = 1'b0; enable_n_i = 1'b1;
        idle_inputs();
        m_tbl = preset_ref(); m_p1 = '0; m_p2 = '0; m_e1 = 1'b1; m_e2 = 1'b1; m_bit = 1'b0;
        @(negedge clk);
        repeat (3) step("R1");
        rst = 1'b0;
        step("R1");
        chk("R1", rd_oe_o, 1'b0, "reset oe");

        // R6: enable takes two edges
        enable_n_i = 1'b0;
        step("R6");
        chk("R6", rd_oe_o, 1'b0, "oe after one edge");
        step("R6");
        chk("R6", rd_oe_o, 1'b1, "oe after two edges");

        // R1 R3: floppy presets all ones
        for (int i = 0; i < 16; i++) read_at(1'b0, 4'(i), 1'b1, "R1 R3");
        // R2 R4: hard-disk presets, phase[3] ignored
        for (int i = 0; i < 8; i++) begin
            read_at(1'b1, 4'(i), (i >= 6), "R2 R4");
            read_at(1'b1, 4'(i + 8), (i >= 6), "R4 phase3 ignored");
        end

        // R7: clear one floppy bit, neighbour unchanged
        write_bit(5, 1'b0);
        read_at(1'b0, 4'd5, 1'b0, "R7");
        read_at(1'b0, 4'd4, 1'b1, "R7 neighbour");

        // R8: write to the addressed bit, visible one edge later
        read_at(1'b0, 4'd9, 1'b1, "R8");
        wr_en_i = 1'b1; wr_idx_i = 5'd9; wr_val_i = 1'b0;
        step("R8");
        idle_inputs();
        chk("R8", rd_data_o, 1'b0, "bypass clear");
        wr_en_i = 1'b1; wr_idx_i = 5'd9; wr_val_i = 1'b1;
        step("R8");
        idle_inputs();
        chk("R8", rd_data_o, 1'b1, "bypass set");

        // R7: out-of-range indices change nothing
        for (int i = 24; i < 32; i++) write_bit(i, 1'b0);
        sweep_all("R7 ignored index");

        // R9: handshake pair
        read_at(1'b1, 4'd2, 1'b0, "R9");
        hs_release_i = 1'b1; step("R9"); idle_inputs();
        chk("R9", rd_data_o, 1'b1, "release");
        hs_assert_i = 1'b1; step("R9"); idle_inputs();
        chk("R9", rd_data_o, 1'b0, "assert");
        hs_release_i = 1'b1; step("R9"); idle_inputs();
        hs_assert_i = 1'b1; hs_release_i = 1'b1; step("R9"); idle_inputs();
        chk("R9", rd_data_o, 1'b0, "both pulses");
        hs_assert_i = 1'b1; wr_en_i = 1'b1; wr_idx_i = 5'd18; wr_val_i = 1'b1;
        step("R9"); idle_inputs();
        chk("R9", rd_data_o, 1'b0, "handshake beats write");
        read_at(1'b1, 4'd3, 1'b0, "R9 high bit");

        // R5: phase latency is three edges
        write_bit(3, 1'b0);
        read_at(1'b0, 4'd4, 1'b1, "R5");
        phase_i = 4'd3;
        step("R5"); chk("R5", rd_data_o, 1'b1, "phase edge 1");
        step("R5"); chk("R5", rd_data_o, 1'b1, "phase edge 2");
        step("R5"); chk("R5", rd_data_o, 1'b0, "phase edge 3");
        // R5: mode latency is one edge
        read_at(1'b0, 4'd0, 1'b1, "R5");
        hd_mode_i = 1'b1;
        step("R5"); chk("R5", rd_data_o, 1'b0, "mode edge 1");

        // R6: disable releases the line after two edges
        enable_n_i = 1'b1;
        step("R6"); chk("R6", rd_oe_o, 1'b1, "still driven");
        step("R6"); chk("R6", rd_oe_o, 1'b0, "released");
        chk("R6", rd_data_o, 1'b0, "data low when released");
        enable_n_i = 1'b0;
        step("R6"); step("R6");

        // random traffic against the reference pipeline
        for (int n = 0; n < 4000; n++) begin
            phase_i      = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) hd_mode_i = ~hd_mode_i;
            if ($urandom_range(0, 31) == 0) enable_n_i = ~enable_n_i;
            wr_en_i      = ($urandom_range(0, 3) == 0);
            wr_idx_i     = 5'($urandom_range(0, 31));
            wr_val_i     = 1'($urandom_range(0, 1));
            hs_assert_i  = ($urandom_range(0, 15) == 0);
            hs_release_i = ($urandom_range(0, 15) == 0);
            step("R3 R4 R7 R8 R9 random");
        end
        idle_inputs();
        enable_n_i = 1'b0;
        step("R6"); step("R6");
        sweep_all("R7 final sweep");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule